// File: doc/BRIEF.md
# Best-Antenna Peak Comparator Sequencer

This block decides which of two antennas delivers the stronger signal during a single measurement window. An external strobe opens the window, and an 8-bit signal-strength sample arrives on every clock. From the rising edge of the window the block runs a fixed schedule of clock counts. It first asserts a peak-detector reset and then raises a control strobe while it tracks the largest sample of the first period. It then asserts the reset again, raises the strobe again and tracks the largest sample of the second period. When the window closes, the block latches whether the second peak is strictly larger than the first.

The window strobe and the samples come from the surrounding radio controller. Antenna switching is done outside the block and is timed from the same schedule: the switch happens during the second reset interval. The control strobe stays high for one clock after the window closes, and the latched best-antenna bit holds until the next window closes.

Top module: `amb_best_antenna`

## Requirements
- R1: While reset is asserted, and until a window opens, `ctrl_o`, `pk_rst_o` and `best_o` are all 0.
- R2: The window edges are counted on clock edges. Edge E0 is the first rising clock edge that samples `win_i` at 1 after it was 0. In the 4 cycles that follow edges E0 to E3, `pk_rst_o` is 1 and `ctrl_o` is 0.
- R3: In the 8 cycles that follow edges E4 to E11, `ctrl_o` is 1 and `pk_rst_o` is 0. The first peak is the maximum of the samples present at edges E5 to E12.
- R4: In the 4 cycles that follow edges E12 to E15, `pk_rst_o` is 1 and `ctrl_o` is 0. From edge E16 onward `ctrl_o` is 1 and `pk_rst_o` is 0 until the window closes. The second peak is the maximum of the samples present at edges E17 to E24.
- R5: At the edge EL that first samples `win_i` at 0, `best_o` takes the value 1 if the second peak is strictly greater than the first, and 0 otherwise.
- R6: In the cycle after EL, `ctrl_o` is 1 and `pk_rst_o` is 0. One cycle later `ctrl_o` is 0.
- R7: `best_o` changes only at a window-closing edge. During a window it keeps the result of the previous window.
- R8: When the window closes early, only the samples at edges before EL count. A period that has not yet begun contributes a peak of 0, so both peaks equal 0 gives `best_o` 0.
- R9: A sample outside the two acquisition ranges has no effect on the result, even a full-scale value of 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_i | input | 1 | Measurement-window strobe |
| smp_i | input | 8 | Signal-strength sample |
| ctrl_o | output | 1 | Acquisition control strobe |
| pk_rst_o | output | 1 | Peak-detector reset |
| best_o | output | 1 | Latched best-antenna result (1 = second period stronger) |

## Verification
The hardest situations to reach are the window closing at every possible edge, including inside a reset interval, and a full-scale sample that falls exactly one edge outside an acquisition range. The bench covers them by sweeping the window length from 1 to 30 edges for each of eight sample patterns. Some patterns place spikes on the edge just before or just after each tracking range; others place equal peaks or single-edge peaks on the first and last tracked edges. The bench computes the expected peaks from the edge indices alone.

// File: rtl/amb_pkg.sv
package amb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RST1 = 3'd1,
    ST_ACQ1 = 3'd2,
    ST_RST2 = 3'd3,
    ST_ACQ2 = 3'd4,
    ST_HOLD = 3'd5,
    ST_TAIL = 3'd6
  } seq_st_t;

  localparam int unsigned NUM_PERIODS = 2;
endpackage

// File: rtl/amb_rst_sync.sv
module amb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/amb_edge.sv
module amb_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic win_i,
  output logic rise_o,
  output logic fall_o
);
  logic win_q;
  logic win_d;

  always_comb win_d = win_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win_d;
  end

  assign rise_o = win_i & ~win_q;
  assign fall_o = ~win_i & win_q;
endmodule

// File: rtl/amb_seq.sv
module amb_seq
  import amb_pkg::*;
#(
  parameter int unsigned RST_CYC = 4,
  parameter int unsigned ACQ_CYC = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rise_i,
  input  logic                   fall_i,
  output logic                   ctrl_o,
  output logic                   pk_rst_o,
  output logic                   latch_o,
  output logic                   start_o,
  output logic [NUM_PERIODS-1:0] trk_o,
  output logic [NUM_PERIODS-1:0] clr_o
);
  localparam int unsigned MAXC = (RST_CYC > ACQ_CYC) ? RST_CYC : ACQ_CYC;
  localparam int unsigned CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] RST_LAST = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] ACQ_LAST = CW'(ACQ_CYC - 1);

  seq_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          active;

  assign active  = (st_q != ST_IDLE) && (st_q != ST_TAIL);
  assign latch_o = fall_i & active;
  assign start_o = rise_i & ~active;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (latch_o) begin
      st_d  = ST_TAIL;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_TAIL: begin
          cnt_d = '0;
          st_d  = start_o ? ST_RST1 : ST_IDLE;
        end
        ST_RST1: begin
          if (cnt_q == RST_LAST) begin st_d = ST_ACQ1; cnt_d = '0; end
          else                   cnt_d = cnt_q + 1'b1;
        end
        ST_ACQ1: begin
          if (cnt_q == ACQ_LAST) begin st_d = ST_RST2; cnt_d = '0; end
          else                   cnt_d = cnt_q + 1'b1;
        end
        ST_RST2: begin
          if (cnt_q == RST_LAST) begin st_d = ST_ACQ2; cnt_d = '0; end
          else                   cnt_d = cnt_q + 1'b1;
        end
        ST_ACQ2: begin
          if (cnt_q == ACQ_LAST) begin st_d = ST_HOLD; cnt_d = '0; end
          else                   cnt_d = cnt_q + 1'b1;
        end
        ST_HOLD: begin
          st_d  = ST_HOLD;
          cnt_d = '0;
        end
        default: begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign ctrl_o   = (st_q == ST_ACQ1) || (st_q == ST_ACQ2) ||
                    (st_q == ST_HOLD) || (st_q == ST_TAIL);
  assign pk_rst_o = (st_q == ST_RST1) || (st_q == ST_RST2);

  assign trk_o[0] = (st_q == ST_ACQ1);
  assign trk_o[1] = (st_q == ST_ACQ2);
  assign clr_o[0] = start_o || (st_q == ST_RST1);
  assign clr_o[1] = start_o || (st_q == ST_RST1) || (st_q == ST_RST2);
endmodule

// File: rtl/amb_peak.sv
module amb_peak #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          trk_i,
  input  logic [DW-1:0] smp_i,
  output logic [DW-1:0] pk_o
);
  logic [DW-1:0] pk_q, pk_d;
  logic          pk_en;

  always_comb begin
    pk_en = clr_i || (trk_i && (smp_i > pk_q));
    pk_d  = clr_i ? '0 : smp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pk_q <= '0;
    else if (pk_en) pk_q <= pk_d;
  end

  assign pk_o = pk_q;
endmodule

// File: rtl/amb_judge.sv
module amb_judge #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch_i,
  input  logic [DW-1:0] pk_first_i,
  input  logic [DW-1:0] pk_second_i,
  output logic          best_o
);
  logic best_q, best_d;

  always_comb best_d = (pk_second_i > pk_first_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       best_q <= 1'b0;
    else if (latch_i) best_q <= best_d;
  end

  assign best_o = best_q;
endmodule

// File: rtl/amb_best_antenna.sv
module amb_best_antenna
  import amb_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned RST_CYC = 4,
  parameter int unsigned ACQ_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_i,
  input  logic [DW-1:0] smp_i,
  output logic          ctrl_o,
  output logic          pk_rst_o,
  output logic          best_o
);
  logic                   rst_ns;
  logic                   rise_p, fall_p;
  logic                   latch_p, start_p;
  logic [NUM_PERIODS-1:0] trk, clr;
  logic [DW-1:0]          pk [NUM_PERIODS];

  amb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  amb_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_ns),
    .win_i  (win_i),
    .rise_o (rise_p),
    .fall_o (fall_p)
  );

  amb_seq #(.RST_CYC(RST_CYC), .ACQ_CYC(ACQ_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_ns),
    .rise_i   (rise_p),
    .fall_i   (fall_p),
    .ctrl_o   (ctrl_o),
    .pk_rst_o (pk_rst_o),
    .latch_o  (latch_p),
    .start_o  (start_p),
    .trk_o    (trk),
    .clr_o    (clr)
  );

  for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_peak
    amb_peak #(.DW(DW)) u_peak (
      .clk   (clk),
      .rst_n (rst_ns),
      .clr_i (clr[g]),
      .trk_i (trk[g]),
      .smp_i (smp_i),
      .pk_o  (pk[g])
    );
  end

  amb_judge #(.DW(DW)) u_judge (
    .clk         (clk),
    .rst_n       (rst_ns),
    .latch_i     (latch_p),
    .pk_first_i  (pk[0]),
    .pk_second_i (pk[1]),
    .best_o      (best_o)
  );
endmodule

// File: rtl/amb_checker.sv
module amb_checker #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_o,
  input logic          pk_rst_o,
  input logic          best_o,
  input logic          start_p,
  input logic          latch_p,
  input logic [DW-1:0] pk_a,
  input logic [DW-1:0] pk_b
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !ctrl_o && !pk_rst_o && !best_o);

  a_r2_start_reset: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> pk_rst_o && !ctrl_o);

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_o && pk_rst_o));

  a_r3_peak_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_p || pk_rst_o) |=> pk_a >= $past(pk_a));

  a_r5_result: assert property (@(posedge clk) disable iff (!rst_n)
    latch_p |=> best_o == $past(pk_b > pk_a));

  a_r5_tie_low: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_p && (pk_a == pk_b)) |=> !best_o);

  a_r6_tail_high: assert property (@(posedge clk) disable iff (!rst_n)
    latch_p |=> ctrl_o && !pk_rst_o);

  a_r6_tail_drop: assert property (@(posedge clk) disable iff (!rst_n)
    latch_p |=> ##1 !ctrl_o);

  a_r7_best_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_p |=> $stable(best_o));
endmodule

bind amb_best_antenna amb_checker #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_ns),
  .ctrl_o   (ctrl_o),
  .pk_rst_o (pk_rst_o),
  .best_o   (best_o),
  .start_p  (start_p),
  .latch_p  (latch_p),
  .pk_a     (pk[0]),
  .pk_b     (pk[1])
);

// File: tb/tb_amb_best_antenna.sv
module tb_amb_best_antenna;
  logic       clk;
  logic       rst_n;
  logic       win_i;
  logic [7:0] smp_i;
  logic       ctrl_o, pk_rst_o, best_o;

  int checks;
  int errors;
  bit exp_best;

  amb_best_antenna dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_i    (win_i),
    .smp_i    (smp_i),
    .ctrl_o   (ctrl_o),
    .pk_rst_o (pk_rst_o),
    .best_o   (best_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] pat_val(int pat, int k);
    case (pat)
      0: return 8'd100;
      1: return 8'(k * 6);
      2: return 8'(250 - k * 6);
      3: return 8'((k * 73 + 29) % 256);
      4: return (k == 10 || k == 20) ? 8'd255 : 8'd3;
      5: return (k == 2 || k == 3 || k == 4 || k == 13 || k == 14 ||
                 k == 15 || k == 16 || k == 25) ? 8'd255 : 8'((k * 5) % 50);
      6: return (k == 12) ? 8'd200 : ((k == 24) ? 8'd201 : 8'd1);
      default: return (k == 5) ? 8'd200 : ((k == 17) ? 8'd199 : 8'd2);
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic run_window(int pat, int len);
    int p1 = 0;
    int p2 = 0;
    for (int k = 5; k <= 12; k++)
      if (k <= len - 1 && pat_val(pat, k) > p1) p1 = pat_val(pat, k);
    for (int k = 17; k <= 24; k++)
      if (k <= len - 1 && pat_val(pat, k) > p2) p2 = pat_val(pat, k);
    win_i = 1'b1;
    smp_i = pat_val(pat, 0);
    for (int k = 0; k < len; k++) begin
      @(posedge clk);
      @(negedge clk);
      // R2 R3 R4 schedule after edge Ek
      if (k <= 3) begin
        chk("R2", "pk_rst", pk_rst_o, 1); chk("R2", "ctrl", ctrl_o, 0);
      end else if (k <= 11) begin
        chk("R3", "ctrl", ctrl_o, 1); chk("R3", "pk_rst", pk_rst_o, 0);
      end else if (k <= 15) begin
        chk("R4", "pk_rst", pk_rst_o, 1); chk("R4", "ctrl", ctrl_o, 0);
      end else begin
        chk("R4", "ctrl", ctrl_o, 1); chk("R4", "pk_rst", pk_rst_o, 0);
      end
      chk("R7", "best held in window", best_o, exp_best);
      smp_i = pat_val(pat, k + 1);
      if (k == len - 1) win_i = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    exp_best = (p2 > p1);
    if (len < 25) chk("R8", "best early close", best_o, exp_best);
    else if (pat == 5) chk("R9", "best ignores outside", best_o, exp_best);
    else chk("R5", "best", best_o, exp_best);
    chk("R6", "ctrl tail", ctrl_o, 1);
    chk("R6", "pk_rst tail", pk_rst_o, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R6", "ctrl after tail", ctrl_o, 0);
    chk("R7", "best after tail", best_o, exp_best);
    smp_i = 8'd255;
    @(posedge clk);
    @(negedge clk);
    chk("R7", "best idle", best_o, exp_best);
    chk("R1", "ctrl idle", ctrl_o, 0);
  endtask

  initial begin
    checks   = 0;
    errors   = 0;
    exp_best = 1'b0;
    rst_n    = 1'b0;
    win_i    = 1'b0;
    smp_i    = 8'd0;
    repeat (3) @(negedge clk);
    chk("R1", "ctrl in reset", ctrl_o, 0);
    chk("R1", "pk_rst in reset", pk_rst_o, 0);
    chk("R1", "best in reset", best_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "ctrl after reset", ctrl_o, 0);
    chk("R1", "best after reset", best_o, 0);
    for (int pat = 0; pat < 8; pat++)
      for (int len = 1; len <= 30; len++)
        run_window(pat, len);
    // R5 tie with equal peaks over a full window
    run_window(4, 28);
    chk("R5", "tie gives 0", best_o, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule